// File: doc/BRIEF.md
# Memory Bus Wait-State Generator with Ready Diagnostics

This block lengthens processor memory cycles so that slow memory devices can still be reached when the processor runs on a fast clock. It watches for the start of each memory cycle: the address-latch strobe seen together with exactly one memory command. When the fast-clock mode input is set, it then pulls the ready output low for a fixed number of clocks. The processor holds the current bus cycle open while ready is low. In slow-clock mode the ready output stays high and cycles complete without waiting.

The block also drives early copies of the address-latch, memory-read and memory-write strobes for the memory array. These come straight from the decoded cycle inputs, with no register in the path, so they lead the processor's own registered bus commands. A single I/O-mapped control bit sits at I/O address 0x8020 and is written through data bit 0. When that bit is set, the ready waveform is copied onto a shared diagnostic line, so an external timer can measure how long the wait lasts. When the bit is clear, the diagnostic line rests high.

Top module: `bus_wait_gen`

## Requirements
- R1: After the asynchronous active-low reset, ready_o is 1, diag_o is 1 and the diagnostic bit is 0.
- R2: With fast_mode_i=1 and ready_o=1, a clock edge that samples ale_i=1 with exactly one of mem_rd_i and mem_wr_i set drives ready_o low from that edge on. ready_o stays low for exactly WAIT_STATES clock cycles and then returns to 1.
- R3: With fast_mode_i=0, no cycle drives ready_o low.
- R4: A cycle that asserts no memory command never starts a wait. This covers ale_i=1 with both memory commands low, and any I/O write. A cycle that asserts mem_rd_i and mem_wr_i together is also treated as no memory cycle.
- R5: A cycle start sampled while ready_o is low is ignored, including on the last low cycle. A start sampled on the first edge after ready_o has returned high is accepted.
- R6: In the same cycle and without a register, elatch_o equals ale_i, emrdc_o equals mem_rd_i AND NOT mem_wr_i, and emwtc_o equals mem_wr_i AND NOT mem_rd_i.
- R7: An edge that samples io_wr_i=1, io_addr_i=0x8020 and io_data_i=1 sets the diagnostic bit. While the bit is set, diag_o equals ready_o.
- R8: An edge that samples io_wr_i=1, io_addr_i=0x8020 and io_data_i=0 clears the diagnostic bit. While the bit is clear, diag_o is 1. I/O writes to any other address leave the bit unchanged.
- R9: With WAIT_STATES=0, ready_o stays 1 even in fast-clock mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_mode_i | input | 1 | Static select: 1 = fast processor clock, wait states used |
| ale_i | input | 1 | Address-latch strobe from the processor status decode |
| mem_rd_i | input | 1 | Memory read command |
| mem_wr_i | input | 1 | Memory write command |
| io_wr_i | input | 1 | I/O write strobe |
| io_addr_i | input | ADDR_W | I/O address |
| io_data_i | input | 1 | I/O write data bit 0 |
| ready_o | output | 1 | Synchronous ready to the processor, low = extend cycle |
| elatch_o | output | 1 | Early address-latch strobe |
| emrdc_o | output | 1 | Early memory-read strobe |
| emwtc_o | output | 1 | Early memory-write strobe |
| diag_o | output | 1 | Diagnostic line, copy of ready_o when enabled, else 1 |

## Verification
The bench builds two instances that are driven from the same stimulus. The main instance uses WAIT_STATES=3, so a wait is long enough that a new start can land on its first, middle and last low cycles. The second instance uses WAIT_STATES=0, which makes the zero-wait case in fast mode observable next to the long wait. The diagnostic bit is then toggled around live waits, so the copied ready waveform and the idle-high level can both be seen on the diagnostic line.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

  // exactly one memory command marks a memory cycle
  function automatic logic is_mem_cycle(input logic rd, input logic wr);
    return rd ^ wr;
  endfunction

  // wait counter update: count down while running, load on an accepted start
  function automatic logic [7:0] next_wait(input logic [7:0] cur,
                                           input logic start,
                                           input logic [7:0] load);
    if (cur != 8'd0) return cur - 8'd1;
    if (start)       return load;
    return 8'd0;
  endfunction

endpackage

// File: rtl/bwg_cycle_detect.sv
module bwg_cycle_detect (
  input  logic fast_mode_i,
  input  logic ale_i,
  input  logic mem_rd_i,
  input  logic mem_wr_i,
  input  logic idle_i,
  output logic start_o,
  output logic elatch_o,
  output logic emrdc_o,
  output logic emwtc_o
);
  import bwg_pkg::*;

  logic mem_cyc;

  always_comb begin
    mem_cyc  = is_mem_cycle(mem_rd_i, mem_wr_i);
    start_o  = ale_i & mem_cyc & fast_mode_i & idle_i;
    elatch_o = ale_i;
    emrdc_o  = mem_rd_i & ~mem_wr_i;
    emwtc_o  = mem_wr_i & ~mem_rd_i;
  end
endmodule

// File: rtl/bwg_wait_counter.sv
module bwg_wait_counter #(
  parameter int WAIT_W      = 3,
  parameter int WAIT_STATES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic idle_o,
  output logic ready_o
);
  import bwg_pkg::*;

  localparam logic [7:0] LOAD = 8'(WAIT_STATES);

  logic [WAIT_W-1:0] cnt_q;
  logic [7:0]        cnt_nx;

  always_comb cnt_nx = next_wait(8'(cnt_q), start_i, LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx[WAIT_W-1:0];
  end

  always_comb begin
    idle_o  = (cnt_q == '0);
    ready_o = idle_o;
  end
endmodule

// File: rtl/bwg_diag_ctl.sv
module bwg_diag_ctl #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] DIAG_ADDR = 16'h8020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_data_i,
  input  logic              ready_i,
  output logic              diag_en_o,
  output logic              diag_o
);
  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(DIAG_ADDR);

  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          en_q <= 1'b0;
    else if (io_wr_i && io_addr_i == HIT) en_q <= io_data_i;
  end

  always_comb begin
    diag_en_o = en_q;
    diag_o    = en_q ? ready_i : 1'b1;
  end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] DIAG_ADDR   = 16'h8020,
  parameter int          WAIT_W      = 3,
  parameter int          WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode_i,
  input  logic              ale_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_data_i,
  output logic              ready_o,
  output logic              elatch_o,
  output logic              emrdc_o,
  output logic              emwtc_o,
  output logic              diag_o
);
  logic start_w;
  logic idle_w;
  logic diag_en_w;

  bwg_cycle_detect u_det (
    .fast_mode_i(fast_mode_i), .ale_i(ale_i), .mem_rd_i(mem_rd_i),
    .mem_wr_i(mem_wr_i), .idle_i(idle_w), .start_o(start_w),
    .elatch_o(elatch_o), .emrdc_o(emrdc_o), .emwtc_o(emwtc_o)
  );

  bwg_wait_counter #(.WAIT_W(WAIT_W), .WAIT_STATES(WAIT_STATES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_i(start_w),
    .idle_o(idle_w), .ready_o(ready_o)
  );

  bwg_diag_ctl #(.ADDR_W(ADDR_W), .DIAG_ADDR(DIAG_ADDR)) u_diag (
    .clk(clk), .rst_n(rst_n), .io_wr_i(io_wr_i), .io_addr_i(io_addr_i),
    .io_data_i(io_data_i), .ready_i(ready_o),
    .diag_en_o(diag_en_w), .diag_o(diag_o)
  );
endmodule

// File: rtl/bwg_chk.sv
module bwg_chk #(
  parameter int WAIT_W      = 3,
  parameter int WAIT_STATES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic fast_mode_i,
  input logic ale_i,
  input logic mem_rd_i,
  input logic mem_wr_i,
  input logic io_wr_i,
  input logic ready_o,
  input logic emrdc_o,
  input logic emwtc_o,
  input logic diag_o,
  input logic start_w,
  input logic diag_en_w
);
  logic [7:0] low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_len <= 8'd0;
    else if (!ready_o) low_len <= low_len + 8'd1;
    else               low_len <= 8'd0;
  end

  generate
    if (WAIT_STATES > 0) begin : g_wait
      assert_wait_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && fast_mode_i && ale_i && (mem_rd_i ^ mem_wr_i)) |=> !ready_o);
    end else begin : g_nowait
      assert_zero_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o);
    end
  endgenerate

  assert_wait_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (low_len == 8'(WAIT_STATES)));

  assert_slow_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !fast_mode_i) |=> ready_o);

  assert_no_mem_no_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !(mem_rd_i ^ mem_wr_i)) |=> ready_o);

  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |-> ready_o);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(emrdc_o && emwtc_o));

  assert_diag_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    diag_en_w |-> (diag_o == ready_o));

  assert_diag_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_en_w |-> diag_o);
endmodule

bind bus_wait_gen bwg_chk #(.WAIT_W(WAIT_W), .WAIT_STATES(WAIT_STATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_mode_i(fast_mode_i), .ale_i(ale_i),
  .mem_rd_i(mem_rd_i), .mem_wr_i(mem_wr_i), .io_wr_i(io_wr_i),
  .ready_o(ready_o), .emrdc_o(emrdc_o), .emwtc_o(emwtc_o), .diag_o(diag_o),
  .start_w(start_w), .diag_en_w(diag_en_w)
);

// File: tb/bus_wait_gen_tb.sv
module bus_wait_gen_tb;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast, ale, rd, wr, iow, iod;
  logic [15:0] ioa;
  logic rdy, el, erd, ewr, dg;
  logic rdy0, el0, erd0, ewr0, dg0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit    q_rdy[$];
  bit    q_dg[$];
  bit    q_rdy0[$];
  string q_tag[$];

  int left = 0;
  bit diag_m = 1'b0;

  always #5 clk = ~clk;

  bus_wait_gen #(.WAIT_STATES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_mode_i(fast), .ale_i(ale),
    .mem_rd_i(rd), .mem_wr_i(wr), .io_wr_i(iow), .io_addr_i(ioa),
    .io_data_i(iod), .ready_o(rdy), .elatch_o(el), .emrdc_o(erd),
    .emwtc_o(ewr), .diag_o(dg));

  bus_wait_gen #(.WAIT_STATES(0)) u_dut0 (
    .clk(clk), .rst_n(rst_n), .fast_mode_i(fast), .ale_i(ale),
    .mem_rd_i(rd), .mem_wr_i(wr), .io_wr_i(iow), .io_addr_i(ioa),
    .io_data_i(iod), .ready_o(rdy0), .elatch_o(el0), .emrdc_o(erd0),
    .emwtc_o(ewr0), .diag_o(dg0));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: one bus clock of stimulus, strobe checks, expected results queued
  task automatic step(input logic a, input logic r, input logic w,
                      input logic f, input logic iw, input logic [15:0] ad,
                      input logic d, input string tag);
    bit start;
    @(negedge clk);
    ale = a; rd = r; wr = w; fast = f; iow = iw; ioa = ad; iod = d;
    #1;
    check({"R6 elatch ", tag}, el, a);
    check({"R6 emrdc ", tag},  erd, r & ~w);
    check({"R6 emwtc ", tag},  ewr, w & ~r);
    start = a && f && (r != w) && (left == 0);
    if (left != 0)  left--;
    else if (start) left = N;
    if (iw && ad == 16'h8020) diag_m = d;
    q_rdy.push_back(left == 0);
    q_dg.push_back(diag_m ? (left == 0) : 1'b1);
    q_rdy0.push_back(1'b1);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, fast, 0, 16'h0, 0, tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (q_tag.size() != 0) begin
      string t;
      t = q_tag.pop_front();
      check({t, " ready"}, rdy, q_rdy.pop_front());
      check({t, " diag"}, dg, q_dg.pop_front());
      check({"R9 zero-wait ready ", t}, rdy0, q_rdy0.pop_front());
    end
  end

  initial begin
    fast = 1; ale = 0; rd = 0; wr = 0; iow = 0; ioa = 0; iod = 0;
    #23;
    check("R1 reset ready", rdy, 1'b1);
    check("R1 reset diag", dg, 1'b1);
    rst_n = 1'b1;
    idle(2, "R1 idle");
    // writing 1 here would enable copy; before that diag stays high during waits
    step(1, 1, 0, 1, 0, 16'h0, 0, "R2 read start");
    idle(5, "R2 read wait");
    step(1, 0, 1, 1, 0, 16'h0, 0, "R2 write start");
    idle(5, "R2 write wait");
    // starts during wait: first, middle, last low cycle ignored
    step(1, 1, 0, 1, 0, 16'h0, 0, "R5 start");
    step(1, 1, 0, 1, 0, 16'h0, 0, "R5 ignored first");
    step(1, 0, 1, 1, 0, 16'h0, 0, "R5 ignored middle");
    step(1, 1, 0, 1, 0, 16'h0, 0, "R5 ignored last");
    step(1, 1, 0, 1, 0, 16'h0, 0, "R5 accepted after");
    idle(5, "R5 tail");
    // slow mode
    step(1, 1, 0, 0, 0, 16'h0, 0, "R3 slow read");
    step(1, 0, 1, 0, 0, 16'h0, 0, "R3 slow write");
    idle(3, "R3 slow idle");
    // no memory command
    step(1, 0, 0, 1, 0, 16'h0, 0, "R4 ale only");
    step(1, 1, 1, 1, 0, 16'h0, 0, "R4 both cmds");
    step(1, 0, 0, 1, 1, 16'h1234, 1, "R4 io write");
    idle(3, "R4 idle");
    // diagnostics
    step(0, 0, 0, 1, 1, 16'h8020, 1, "R7 enable");
    step(1, 0, 1, 1, 0, 16'h0, 0, "R7 wait copied");
    idle(5, "R7 copy");
    step(0, 0, 0, 1, 1, 16'h8021, 0, "R8 other addr");
    step(1, 1, 0, 1, 0, 16'h0, 0, "R8 still copied");
    step(0, 0, 0, 1, 1, 16'h8020, 0, "R8 disable mid-wait");
    idle(5, "R8 idle high");
    step(1, 1, 0, 1, 0, 16'h0, 0, "R8 wait not copied");
    idle(5, "R8 tail");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule